// File: doc/BRIEF.md
# Attention and Command Issue Sequencer

This block starts an operation on a disk attachment controller from the host side. A single start pulse hands it a command code, a target device number, an options field, a length select and up to three argument words. The sequencer first runs the attention handshake against the controller. It turns controller interrupts off, waits for the controller to report not-busy, writes the attention value, and then turns interrupts back on. It then feeds the command block into the controller's command register one word at a time. After each word it waits for the controller to drain that register. Once the last word is in, it waits for the controller to drop its in-progress flag.

The controller's registers are reached through a plain single-cycle read/write port. A read returns data in the same cycle. Each of the three waits has its own attempt limit, and the sequencer reports a distinct error code for each kind of timeout. The completion wait is sized in seconds and scaled by a clock-frequency parameter. Two other inputs change the flow. One skips the not-busy wait, for an attention that acknowledges a reset-completed interrupt. The other ends the operation after the attention step, for attentions that carry no command block.

Top module: `attn_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low, `err_code` is 0, and the register port neither reads nor writes until `start`.
- R2: An accepted start drives writes in this fixed order: control register (address 0) with 0x0000, status polls (address 3), attention register (address 1), then control register with only the interrupt-enable bit (0x0001).
- R3: The attention write carries the 5-bit attention code in bits 4:0, the device number in bits 7:5, and zeros in bits 15:8.
- R4: With `skip_busy_poll` high, no status read happens between the control write of 0 and the attention write.
- R5: Status bit 0 is controller-busy. After POLL_LIMIT status reads that all show it set, the run ends with `err_code` 1 and no further writes.
- R6: Command word 0 is {length code in bits 15:14 (00 for 2 words, 01 for 4 words), options in 13:8, device in 7:5, command code in 4:0}.
- R7: Command words go to address 2 in order: word 0, then argument words 1 (`arg_words[15:0]`), 2 and 3. A short command sends words 0 and 1 and a long command sends all four.
- R8: Status bit 1 is command-register-full. After each command word the block reads status until that bit is clear before the next write. After POLL_LIMIT full reads it ends with `err_code` 2 and writes nothing more.
- R9: Status bit 2 is command-in-progress. After the last word the block reads status until that bit is clear, for at most CLK_HZ*WAIT_SEC reads, and on expiry ends with `err_code` 3.
- R10: When in-progress clears, the result is `err_code` 0 if `cmd_good` is high and 4 if it is low. `error` is high exactly when `err_code` is nonzero.
- R11: `done` is a one-cycle pulse with `busy` low in that cycle. `error` and `err_code` hold until the next accepted start.
- R12: With `attn_only` high, the run finishes without error right after the interrupt-enable write and sends no command word.
- R13: A `start` while `busy` is high is ignored, and the operation in flight keeps its latched fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted while idle |
| cmd_code | input | 5 | Command code |
| dev_no | input | 3 | Target device number |
| cmd_opts | input | 6 | Command options field |
| long_cmd | input | 1 | 1 selects the 4-word block, 0 the 2-word block |
| arg_words | input | 48 | Argument words 1..3, word 1 in the low bits |
| attn_code | input | 5 | Attention type code |
| skip_busy_poll | input | 1 | Skip the not-busy wait |
| attn_only | input | 1 | Finish after the attention step |
| cmd_good | input | 1 | Completion state reported done by the interrupt side |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last operation failed |
| err_code | output | 3 | 0 ok, 1 busy timeout, 2 word not taken, 3 completion timeout, 4 failed |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 2 | 0 control, 1 attention, 2 command word, 3 status |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid in the cycle of `reg_rd` |

## Verification
The assertions assume the controller answers a status read in the same cycle. They also assume `reg_rdata` reflects only the controller's own flags and never echoes anything written. The bench's controller model builds each status word from down-counters that move only on status reads, so it keeps to that contract. The checks on a word write following an empty full-flag rely on the sequencer being the only party that writes the command register. The bench is the only writer, and it pulses `start` only from the idle state, apart from one deliberate intrusion that tests R13.

// File: rtl/attn_seq_pkg.sv
package attn_seq_pkg;

    localparam int DW = 16;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_ATTN = 2'd1,
        RA_CMDW = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    localparam int SB_BUSY   = 0;
    localparam int SB_FULL   = 1;
    localparam int SB_INPROG = 2;

    localparam logic [DW-1:0] CTRL_OFF   = 16'h0000;
    localparam logic [DW-1:0] CTRL_INTEN = 16'h0001;

    typedef enum logic [2:0] {
        E_NONE    = 3'd0,
        E_BUSY_TO = 3'd1,
        E_SLOW    = 3'd2,
        E_CMPL_TO = 3'd3,
        E_FAILED  = 3'd4
    } err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTL_OFF,
        S_BUSY_POLL,
        S_ATTN_WR,
        S_CTL_ON,
        S_WORD_WR,
        S_FULL_POLL,
        S_CMPL_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [4:0] code;
        logic [2:0] dev;
        logic [5:0] opts;
        logic       long_cmd;
    } cmd_hdr_t;

    function automatic logic [DW-1:0] make_word0(cmd_hdr_t h);
        return {1'b0, h.long_cmd, h.opts, h.dev, h.code};
    endfunction

    function automatic logic [DW-1:0] make_attn(logic [4:0] code, logic [2:0] dev);
        return {8'h00, dev, code};
    endfunction

endpackage

// File: rtl/attn_poll_ctr.sv
module attn_poll_ctr #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/attn_word_buf.sv
module attn_word_buf
    import attn_seq_pkg::*;
#(
    parameter int MAXW = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  cmd_hdr_t               hdr,
    input  logic [(MAXW-1)*DW-1:0] args,
    input  logic [1:0]             idx,
    output logic [DW-1:0]          word,
    output logic [1:0]             last_idx
);
    logic [DW-1:0] words_q [MAXW];
    logic          long_q;

    for (genvar i = 0; i < MAXW; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words_q[i] <= '0;
            else if (load) begin
                if (i == 0)
                    words_q[i] <= make_word0(hdr);
                else
                    words_q[i] <= args[(i-1)*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            long_q <= 1'b0;
        else if (load)
            long_q <= hdr.long_cmd;
    end

    assign word     = words_q[idx];
    assign last_idx = long_q ? 2'd3 : 2'd1;
endmodule

// File: rtl/attn_seq_fsm.sv
module attn_seq_fsm
    import attn_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  cmd_hdr_t      hdr,
    input  logic [4:0]    attn_code,
    input  logic          skip_busy_poll,
    input  logic          attn_only,
    input  logic          cmd_good,
    input  logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] cur_word,
    input  logic [1:0]    last_idx,
    input  logic          short_last,
    input  logic          cmpl_last,
    output logic          load,
    output logic [1:0]    word_idx,
    output logic          short_clr,
    output logic          short_step,
    output logic          cmpl_clr,
    output logic          cmpl_step,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic [1:0]    reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [2:0]    err_code
);
    seq_state_e state_q, state_d;
    logic [1:0] idx_q, idx_d;
    logic [2:0] dev_q;
    logic [4:0] attn_q;
    logic       skip_q, aonly_q;
    logic       fin;
    err_e       fin_code, err_q;
    logic       done_q;

    logic st_busy, st_full, st_inprog;
    assign st_busy   = reg_rdata[SB_BUSY];
    assign st_full   = reg_rdata[SB_FULL];
    assign st_inprog = reg_rdata[SB_INPROG];

    assign load = (state_q == S_IDLE) && start;

    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        fin      = 1'b0;
        fin_code = E_NONE;
        case (state_q)
            S_IDLE:      if (start) state_d = S_CTL_OFF;
            S_CTL_OFF:   state_d = skip_q ? S_ATTN_WR : S_BUSY_POLL;
            S_BUSY_POLL: begin
                if (!st_busy)
                    state_d = S_ATTN_WR;
                else if (short_last) begin
                    fin      = 1'b1;
                    fin_code = E_BUSY_TO;
                end
            end
            S_ATTN_WR:   state_d = S_CTL_ON;
            S_CTL_ON: begin
                idx_d = 2'd0;
                if (aonly_q) begin
                    fin      = 1'b1;
                    fin_code = E_NONE;
                end else
                    state_d = S_WORD_WR;
            end
            S_WORD_WR:   state_d = S_FULL_POLL;
            S_FULL_POLL: begin
                if (!st_full) begin
                    if (idx_q == last_idx)
                        state_d = S_CMPL_WAIT;
                    else begin
                        idx_d   = idx_q + 2'd1;
                        state_d = S_WORD_WR;
                    end
                end else if (short_last) begin
                    fin      = 1'b1;
                    fin_code = E_SLOW;
                end
            end
            S_CMPL_WAIT: begin
                if (!st_inprog) begin
                    fin      = 1'b1;
                    fin_code = cmd_good ? E_NONE : E_FAILED;
                end else if (cmpl_last) begin
                    fin      = 1'b1;
                    fin_code = E_CMPL_TO;
                end
            end
            default:     state_d = S_IDLE;
        endcase
        if (fin)
            state_d = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            dev_q   <= '0;
            attn_q  <= '0;
            skip_q  <= 1'b0;
            aonly_q <= 1'b0;
            err_q   <= E_NONE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            done_q  <= fin;
            if (load) begin
                dev_q   <= hdr.dev;
                attn_q  <= attn_code;
                skip_q  <= skip_busy_poll;
                aonly_q <= attn_only;
                err_q   <= E_NONE;
            end else if (fin)
                err_q <= fin_code;
        end
    end

    always_comb begin
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_addr  = RA_CTRL;
        reg_wdata = '0;
        case (state_q)
            S_CTL_OFF: begin
                reg_wr    = 1'b1;
                reg_addr  = RA_CTRL;
                reg_wdata = CTRL_OFF;
            end
            S_ATTN_WR: begin
                reg_wr    = 1'b1;
                reg_addr  = RA_ATTN;
                reg_wdata = make_attn(attn_q, dev_q);
            end
            S_CTL_ON: begin
                reg_wr    = 1'b1;
                reg_addr  = RA_CTRL;
                reg_wdata = CTRL_INTEN;
            end
            S_WORD_WR: begin
                reg_wr    = 1'b1;
                reg_addr  = RA_CMDW;
                reg_wdata = cur_word;
            end
            S_BUSY_POLL, S_FULL_POLL, S_CMPL_WAIT: begin
                reg_rd   = 1'b1;
                reg_addr = RA_STAT;
            end
            default: ;
        endcase
    end

    assign short_clr  = !((state_q == S_BUSY_POLL) || (state_q == S_FULL_POLL));
    assign short_step = ((state_q == S_BUSY_POLL) && st_busy) ||
                        ((state_q == S_FULL_POLL) && st_full);
    assign cmpl_clr   = (state_q != S_CMPL_WAIT);
    assign cmpl_step  = (state_q == S_CMPL_WAIT) && st_inprog;

    assign word_idx = idx_q;
    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign err_code = err_q;
    assign error    = (err_q != E_NONE);
endmodule

// File: rtl/attn_cmd_seq.sv
module attn_cmd_seq
    import attn_seq_pkg::*;
#(
    parameter int POLL_LIMIT = 10000,
    parameter int CLK_HZ     = 100_000_000,
    parameter int WAIT_SEC   = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [4:0]  cmd_code,
    input  logic [2:0]  dev_no,
    input  logic [5:0]  cmd_opts,
    input  logic        long_cmd,
    input  logic [47:0] arg_words,
    input  logic [4:0]  attn_code,
    input  logic        skip_busy_poll,
    input  logic        attn_only,
    input  logic        cmd_good,
    output logic        busy,
    output logic        done,
    output logic        error,
    output logic [2:0]  err_code,
    output logic        reg_wr,
    output logic        reg_rd,
    output logic [1:0]  reg_addr,
    output logic [15:0] reg_wdata,
    input  logic [15:0] reg_rdata
);
    localparam int MAXW     = 4;
    localparam int CMPL_CYC = CLK_HZ * WAIT_SEC;

    cmd_hdr_t      hdr;
    logic          load;
    logic [1:0]    word_idx, last_idx;
    logic [DW-1:0] cur_word;
    logic          short_clr, short_step, short_last;
    logic          cmpl_clr, cmpl_step, cmpl_last;

    assign hdr = '{code: cmd_code, dev: dev_no, opts: cmd_opts, long_cmd: long_cmd};

    attn_word_buf #(.MAXW(MAXW)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .hdr      (hdr),
        .args     (arg_words),
        .idx      (word_idx),
        .word     (cur_word),
        .last_idx (last_idx)
    );

    attn_poll_ctr #(.LIMIT(POLL_LIMIT)) u_short_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (short_clr),
        .step (short_step),
        .last (short_last)
    );

    attn_poll_ctr #(.LIMIT(CMPL_CYC)) u_cmpl_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (cmpl_clr),
        .step (cmpl_step),
        .last (cmpl_last)
    );

    attn_seq_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .hdr            (hdr),
        .attn_code      (attn_code),
        .skip_busy_poll (skip_busy_poll),
        .attn_only      (attn_only),
        .cmd_good       (cmd_good),
        .reg_rdata      (reg_rdata),
        .cur_word       (cur_word),
        .last_idx       (last_idx),
        .short_last     (short_last),
        .cmpl_last      (cmpl_last),
        .load           (load),
        .word_idx       (word_idx),
        .short_clr      (short_clr),
        .short_step     (short_step),
        .cmpl_clr       (cmpl_clr),
        .cmpl_step      (cmpl_step),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .busy           (busy),
        .done           (done),
        .error          (error),
        .err_code       (err_code)
    );
endmodule

// File: rtl/attn_cmd_seq_chk.sv
module attn_cmd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic [2:0]  err_code,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!reg_wr && !reg_rd));

    a_r1_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    a_r2_disable_first: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (reg_wr && reg_addr == 2'd0 && reg_wdata == 16'h0000));

    a_r2_enable_after_attn: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1) |=> (reg_wr && reg_addr == 2'd0 && reg_wdata == 16'h0001));

    a_r3_attn_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1) |-> (reg_wdata[15:8] == 8'h00));

    a_r8_poll_after_word: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2) |=> (reg_rd && reg_addr == 2'd3));

    a_r8_word_needs_empty: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2) |-> !$past(reg_rd && reg_addr == 2'd3 && reg_rdata[1]));

    a_r10_error_matches_code: assert property (@(posedge clk) disable iff (rst)
        error == (err_code != 3'd0));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r11_error_held: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && !start) |=> $stable(err_code));
endmodule

bind attn_cmd_seq attn_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .err_code  (err_code),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/test_attn_cmd_seq.sv
`timescale 1ns/1ps
module test_attn_cmd_seq;
    localparam int L   = 6;
    localparam int CHZ = 10;
    localparam int WS  = 2;
    localparam int C   = CHZ * WS;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  cmd_code;
    logic [2:0]  dev_no;
    logic [5:0]  cmd_opts;
    logic        long_cmd;
    logic [47:0] arg_words;
    logic [4:0]  attn_code;
    logic        skip_busy_poll, attn_only, cmd_good;
    logic        busy, done, error;
    logic [2:0]  err_code;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    always #4 clk = ~clk;

    attn_cmd_seq #(.POLL_LIMIT(L), .CLK_HZ(CHZ), .WAIT_SEC(WS)) i_attn_cmd_seq (
        .clk(clk), .rst(rst), .start(start), .cmd_code(cmd_code), .dev_no(dev_no),
        .cmd_opts(cmd_opts), .long_cmd(long_cmd), .arg_words(arg_words),
        .attn_code(attn_code), .skip_busy_poll(skip_busy_poll), .attn_only(attn_only),
        .cmd_good(cmd_good), .busy(busy), .done(done), .error(error), .err_code(err_code),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // controller model
    int cfg_bd, cfg_fd, cfg_id, n_exp;
    bit clr_model;
    int busy_left, full_left, inprog_left, words_seen, nlog, nreads;
    bit seen_clear;
    logic [1:0]  la [16];
    logic [15:0] ld [16];

    assign reg_rdata = {13'd0,
                        (words_seen == n_exp) && seen_clear && (inprog_left > 0),
                        (full_left > 0),
                        (busy_left > 0)};

    always @(posedge clk) begin
        if (clr_model) begin
            busy_left   <= cfg_bd;
            full_left   <= 0;
            inprog_left <= cfg_id;
            words_seen  <= 0;
            nlog        <= 0;
            nreads      <= 0;
            seen_clear  <= 1'b0;
        end else begin
            if (reg_rd && reg_addr == 2'd3) begin
                nreads <= nreads + 1;
                if (busy_left > 0) busy_left <= busy_left - 1;
                if (full_left > 0) full_left <= full_left - 1;
                else if (words_seen == n_exp) begin
                    if (!seen_clear) seen_clear <= 1'b1;
                    else if (inprog_left > 0) inprog_left <= inprog_left - 1;
                end
            end
            if (reg_wr) begin
                if (nlog < 16) begin
                    la[nlog] <= reg_addr;
                    ld[nlog] <= reg_wdata;
                end
                nlog <= nlog + 1;
                if (reg_addr == 2'd2) begin
                    full_left  <= cfg_fd;
                    words_seen <= words_seen + 1;
                end
            end
        end
    end

    int total = 0, bad = 0, cycles = 0;
    bit wd_hit = 1'b0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !wd_hit) begin
            wd_hit <= 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int dev, input int code, input int opts, input int lng,
                       input int bd, input int fd, input int id, input int skp,
                       input int aonly, input int good, input bit intrude, input string tag);
        int n, pre, exp_err, exp_reads, exp_nw, w;
        int wv [4];
        bit ended;
        n = lng ? 4 : 2;
        @(negedge clk);
        cfg_bd = bd; cfg_fd = fd; cfg_id = id; n_exp = n;
        cmd_code = code[4:0]; dev_no = dev[2:0]; cmd_opts = opts[5:0];
        long_cmd = lng[0];
        arg_words = {16'(code * 97 + 3), 16'(dev * 4099 + opts), 16'(bd * 257 + fd + 16'h5a00)};
        attn_code = 5'(code + 3);
        skip_busy_poll = skp[0]; attn_only = aonly[0]; cmd_good = good[0];
        clr_model = 1'b1;
        @(negedge clk);
        clr_model = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            @(negedge clk);
            start = 1'b1; dev_no = 3'(dev + 1); attn_code = 5'(code + 9);
            @(negedge clk);
            start = 1'b0; dev_no = dev[2:0]; attn_code = 5'(code + 3);
        end
        ended = 1'b0;
        for (int k = 0; k < 400 && !ended; k++) begin
            if (done) ended = 1'b1;
            else @(negedge clk);
        end
        chk(ended, {"R11 done seen ", tag}, ended, 1);
        chk(!busy, {"R11 busy low at done ", tag}, busy, 0);

        wv[0] = (lng << 14) | (opts << 8) | (dev << 5) | code;
        wv[1] = int'(arg_words[15:0]);
        wv[2] = int'(arg_words[31:16]);
        wv[3] = int'(arg_words[47:32]);
        pre = skp ? 0 : (bd + 1);
        if (!skp && bd >= L) begin
            exp_err = 1; exp_nw = 1; exp_reads = L;
        end else if (aonly) begin
            exp_err = 0; exp_nw = 3; exp_reads = pre;
        end else if (fd >= L) begin
            exp_err = 2; exp_nw = 4; exp_reads = pre + L;
        end else begin
            exp_nw = 3 + n;
            exp_reads = pre + n * (fd + 1);
            if (id >= C) begin
                exp_err = 3; exp_reads += C;
            end else begin
                exp_err = good ? 0 : 4; exp_reads += id + 1;
            end
        end
        chk(err_code == 3'(exp_err), {"R5 R8 R9 R10 err_code ", tag}, err_code, exp_err);
        chk(error == (exp_err != 0), {"R10 error flag ", tag}, error, exp_err != 0);
        chk(nlog == exp_nw, {"R2 R7 R12 write count ", tag}, nlog, exp_nw);
        chk(nreads == exp_reads, {"R4 R5 R8 R9 status reads ", tag}, nreads, exp_reads);
        // R2 order
        chk(la[0] == 2'd0 && ld[0] == 16'h0000, {"R2 ctrl off ", tag}, ld[0], 0);
        if (exp_nw >= 3) begin
            w = (dev << 5) | ((code + 3) & 31);
            chk(la[1] == 2'd1 && ld[1] == 16'(w), {"R3 R13 attn value ", tag}, ld[1], w);
            chk(la[2] == 2'd0 && ld[2] == 16'h0001, {"R2 ctrl enable ", tag}, ld[2], 1);
        end
        for (int j = 3; j < exp_nw; j++)
            chk(la[j] == 2'd2 && ld[j] == 16'(wv[j-3]), {"R6 R7 command word ", tag},
                ld[j], wv[j-3]);
        @(negedge clk);
        chk(!done, {"R11 done one cycle ", tag}, done, 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; clr_model = 1'b1;
        cfg_bd = 0; cfg_fd = 0; cfg_id = 0; n_exp = 2;
        cmd_code = '0; dev_no = '0; cmd_opts = '0; long_cmd = 1'b0; arg_words = '0;
        attn_code = '0; skip_busy_poll = 1'b0; attn_only = 1'b0; cmd_good = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        clr_model = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !error, "R1 reset outputs", {busy, done, error}, 0);
        chk(err_code == 3'd0, "R1 reset err_code", err_code, 0);
        chk(nlog == 0 && nreads == 0, "R1 no access before start", nlog + nreads, 0);

        // main sweep: device, length, busy delay up to and past the limit (R2 R3 R5 R6 R7 R8)
        for (int d = 0; d < 8; d++)
            for (int lg = 0; lg < 2; lg++)
                for (int b = 0; b <= L; b++)
                    run(d, (d * 5 + b * 3 + lg) % 32, (d * 7 + b) % 64, lg, b,
                        (d + b) % 3, d % 4, 0, 0, 1, 1'b0, "sweep");

        // R8 word not taken, boundary on both sides
        for (int lg = 0; lg < 2; lg++) begin
            run(2, 9, 33, lg, 1, L - 1, 0, 0, 0, 1, 1'b0, "full edge ok");
            run(2, 9, 33, lg, 1, L, 0, 0, 0, 1, 1'b0, "full timeout");
        end
        // R9 completion window
        run(3, 17, 5, 0, 0, 0, C - 1, 0, 0, 1, 1'b0, "cmpl edge ok");
        run(3, 17, 5, 1, 0, 0, C, 0, 0, 1, 1'b0, "cmpl timeout");
        run(3, 17, 5, 0, 2, 1, C + 7, 0, 0, 1, 1'b0, "cmpl timeout far");
        // R10 completion not done
        run(5, 31, 63, 1, 0, 0, 3, 0, 0, 0, 1'b0, "failed");
        // R11 error held through idle cycles
        repeat (5) @(negedge clk);
        chk(err_code == 3'd4 && error, "R11 error held while idle", err_code, 4);
        // R4 skip poll with controller still busy
        run(6, 12, 1, 0, 40, 0, 0, 1, 0, 1, 1'b0, "skip poll");
        run(7, 12, 1, 1, 40, 2, 2, 1, 0, 1, 1'b0, "skip poll long");
        // R12 attention only
        run(1, 20, 0, 0, 2, 0, 0, 0, 1, 1, 1'b0, "attn only");
        run(4, 21, 0, 1, 0, 0, 0, 1, 1, 0, 1'b0, "attn only skip");
        // R13 start while busy ignored
        run(2, 6, 10, 1, 3, 1, 2, 0, 0, 1, 1'b1, "intrude");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule